// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two 32-bit operands and either stores the product or adds it to a 64-bit accumulator. The accumulator is held as two 32-bit halves: a high word and a low word. There are four operations:

- a signed 32x32 multiply;
- an unsigned 32x32 multiply;
- a 16x16 signed multiply-accumulate on the low operand halves;
- a 32x32 signed multiply-accumulate on the full 64-bit pair.

The two multiplies overwrite the accumulator. The two accumulates add to it. A saturation flag sent with each operation changes how the accumulates finish.

The 16x16 accumulate depends on that flag. Without saturation, it keeps a 42-bit running total: ten significant bits in the high word, sign-extended to 32 bits. With saturation, it clamps the low word to the signed 32-bit range and records any overflow in a sticky bit at high-word bit 0. The 32x32 accumulate with saturation trims the result to a 48-bit form.

A host starts an operation with a one-cycle strobe and sees a one-cycle done pulse when the new accumulator value is visible. A synchronous clear and per-half direct writes let the host set up or reset the accumulator between operations.

Top module: `mac_unit`

## Requirements
- R1: Opcode 2'b00 forms the signed 64-bit product of `op_a` and `op_b`. Bits 63:32 go to `acc_hi` and bits 31:0 go to `acc_lo`.
- R2: Opcode 2'b01 forms the unsigned 64-bit product and splits it the same way as R1.
- R3: Opcode 2'b10 with `sat_en`=0 adds the signed product of `op_a[15:0]` and `op_b[15:0]` to a 42-bit total. The total is formed from `acc_hi[9:0]` (signed) above `acc_lo`. After the add, `acc_hi` holds bits 41:32 of the new total, sign-extended from bit 9.
- R4: Opcode 2'b10 with `sat_en`=1 adds the 16x16 product to `acc_lo` as a signed 32-bit value. On signed overflow, `acc_lo` becomes 32'h80000000 for a negative product and 32'h7FFFFFFF otherwise, and bit 0 of `acc_hi` is set. The other bits of `acc_hi` are left unchanged.
- R5: A saturating 16x16 accumulate never clears `acc_hi[0]`. Without overflow it leaves `acc_hi` unchanged.
- R6: Opcode 2'b11 with `sat_en`=0 adds the signed 64-bit product of `op_a` and `op_b` to {`acc_hi`,`acc_lo`}, wrapping modulo 2^64.
- R7: Opcode 2'b11 with `sat_en`=1 does the add of R6 and then reshapes `acc_hi`. If bit 31 of the sum's high word is 1, bits 31:15 are forced to 1. Otherwise they are cleared. Bits 14:0 are kept.
- R8: `clr` zeroes both halves at the next clock edge. It overrides writes and any completing operation.
- R9: `wr_hi` or `wr_lo` loads `wr_data` into that half at the next edge. A write overrides a result completing in the same cycle. The half that is not written still takes the result.
- R10: A start accepted at edge k raises `done` for exactly one cycle after edge k+1. The result is visible in that same cycle. The opcode, operands and `sat_en` are captured at edge k. The accumulator is read at edge k+1.
- R11: A `start` while the unit is busy (the cycle after an accepted start) is ignored and produces no second `done`.
- R12: Reset clears `acc_hi`, `acc_lo` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation strobe |
| opcode | input | 2 | Operation select |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sat_en | input | 1 | Saturation mode for accumulates |
| clr | input | 1 | Synchronous accumulator clear |
| wr_hi | input | 1 | Load high word from wr_data |
| wr_lo | input | 1 | Load low word from wr_data |
| wr_data | input | 32 | Direct write data |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest states to reach from the ports are signed overflow in the saturating 16x16 accumulate and the carry that crosses bit 9 of the 42-bit total. Random operands almost never hit either one. The stimulus therefore uses direct writes to put the low word next to 32'h7FFFFFFF or 32'h80000000, and the high word next to the 10-bit boundary. It then applies extreme halfword products such as 16'h7FFF squared and 16'h8000 times 16'h7FFF. A random phase then mixes these extreme operands with writes, clears and start strobes that arrive while the unit is busy.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MULS  = 2'b00,
    OP_MULU  = 2'b01,
    OP_MAC16 = 2'b10,
    OP_MAC32 = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          sat_in,
  output logic          busy,
  output mac_op_e       op_q,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q,
  output logic          sat_q,
  output logic          done
);
  logic accept;
  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      op_q  <= OP_MULS;
      a_q   <= '0;
      b_q   <= '0;
      sat_q <= 1'b0;
    end else begin
      busy <= accept;
      done <= busy;
      if (accept) begin
        op_q  <= mac_op_e'(op_in);
        a_q   <= a_in;
        b_q   <= b_in;
        sat_q <= sat_in;
      end
    end
  end

  // R10: done arrives two edges after an accepted start
  a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> ##1 done);
  // R11: a start while busy gives no second pulse
  a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_no_busy_chain: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int GUARD = 10
) (
  input  mac_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sat,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  output logic [DW-1:0] nxt_hi,
  output logic [DW-1:0] nxt_lo,
  output logic          sat_ovf
);
  localparam int HW   = DW / 2;
  localparam int AW   = 2 * DW;
  localparam int KEEP = HW - 1;

  function automatic logic [AW-1:0] f_mul_s(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic signed [AW-1:0] xs, ys;
    xs = {{DW{x[DW-1]}}, x};
    ys = {{DW{y[DW-1]}}, y};
    return AW'(xs * ys);
  endfunction

  function automatic logic [AW-1:0] f_mul_u(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [AW-1:0] xu, yu;
    xu = {{DW{1'b0}}, x};
    yu = {{DW{1'b0}}, y};
    return xu * yu;
  endfunction

  function automatic logic [DW-1:0] f_prod16(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic signed [DW-1:0] xs, ys;
    xs = {{HW{x[HW-1]}}, x[HW-1:0]};
    ys = {{HW{y[HW-1]}}, y[HW-1:0]};
    return DW'(xs * ys);
  endfunction

  // returns {overflow, hi, lo}
  function automatic logic [AW:0] f_mac16(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                          input logic s, input logic [DW-1:0] h,
                                          input logic [DW-1:0] l);
    logic [DW-1:0] p, h_n, l_n, h_t;
    logic [DW:0]   sum;
    logic          ovf;
    p   = f_prod16(x, y);
    sum = {1'b0, l} + {1'b0, p};
    ovf = 1'b0;
    h_n = h;
    l_n = sum[DW-1:0];
    if (s) begin
      ovf = (p[DW-1] == l[DW-1]) && (sum[DW-1] != p[DW-1]);
      if (ovf) begin
        h_n = h | DW'(1);
        l_n = p[DW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      end
    end else begin
      h_t = h + {DW{p[DW-1]}} + DW'(sum[DW]);
      h_n = {{(DW-GUARD){h_t[GUARD-1]}}, h_t[GUARD-1:0]};
    end
    return {ovf, h_n, l_n};
  endfunction

  function automatic logic [AW-1:0] f_mac32(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                           input logic s, input logic [DW-1:0] h,
                                           input logic [DW-1:0] l);
    logic [AW-1:0] full;
    logic [DW-1:0] h_n;
    full = {h, l} + f_mul_s(x, y);
    h_n  = full[AW-1:DW];
    if (s) h_n = {{(DW-KEEP){h_n[DW-1]}}, h_n[KEEP-1:0]};
    return {h_n, full[DW-1:0]};
  endfunction

  logic [AW:0]   r16;
  logic [AW-1:0] res;

  always_comb begin
    r16     = f_mac16(a, b, sat, hi, lo);
    sat_ovf = 1'b0;
    unique case (op)
      OP_MULS:  res = f_mul_s(a, b);
      OP_MULU:  res = f_mul_u(a, b);
      OP_MAC16: begin
        res     = r16[AW-1:0];
        sat_ovf = r16[AW];
      end
      default:  res = f_mac32(a, b, sat, hi, lo);
    endcase
    nxt_hi = res[AW-1:DW];
    nxt_lo = res[DW-1:0];
  end

  // R4: a flagged overflow always yields one of the two clamp values with bit 0 set
  a_r4_clamp_value: assert final (!sat_ovf ||
    ((nxt_lo == {1'b1, {(DW-1){1'b0}}} || nxt_lo == {1'b0, {(DW-1){1'b1}}}) && nxt_hi[0]));
endmodule

// File: rtl/mac_regs.sv
module mac_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wr_data,
  input  logic          fin,
  input  logic [DW-1:0] nxt_hi,
  input  logic [DW-1:0] nxt_lo,
  output logic [DW-1:0] hi,
  output logic [DW-1:0] lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= '0;
      lo <= '0;
    end else if (clr) begin
      hi <= '0;
      lo <= '0;
    end else begin
      if (wr_hi)    hi <= wr_data;
      else if (fin) hi <= nxt_hi;
      if (wr_lo)    lo <= wr_data;
      else if (fin) lo <= nxt_lo;
    end
  end

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hi == '0 && lo == '0));
  a_r9_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wr_hi) |=> hi == $past(wr_data));
  a_r9_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wr_lo) |=> lo == $past(wr_data));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_hi && !wr_lo && !fin) |=> ($stable(hi) && $stable(lo)));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int GUARD = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    opcode,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          sat_en,
  input  logic          clr,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo,
  output logic          done
);
  localparam int KEEP = DW / 2 - 1;

  logic          fin;
  mac_op_e       op_q;
  logic [DW-1:0] a_q, b_q;
  logic          sat_q;
  logic [DW-1:0] nxt_hi, nxt_lo;
  logic          sat_ovf;

  mac_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(opcode),
    .a_in(op_a), .b_in(op_b), .sat_in(sat_en),
    .busy(fin), .op_q(op_q), .a_q(a_q), .b_q(b_q), .sat_q(sat_q), .done(done)
  );

  mac_datapath #(.DW(DW), .GUARD(GUARD)) u_dp (
    .op(op_q), .a(a_q), .b(b_q), .sat(sat_q), .hi(acc_hi), .lo(acc_lo),
    .nxt_hi(nxt_hi), .nxt_lo(nxt_lo), .sat_ovf(sat_ovf)
  );

  mac_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .fin(fin), .nxt_hi(nxt_hi), .nxt_lo(nxt_lo),
    .hi(acc_hi), .lo(acc_lo)
  );

  logic mac16_sat_fin, mac16_wrap_fin, mac32_sat_fin;
  assign mac16_sat_fin  = fin && op_q == OP_MAC16 && sat_q && !clr && !wr_hi;
  assign mac16_wrap_fin = fin && op_q == OP_MAC16 && !sat_q && !clr && !wr_hi;
  assign mac32_sat_fin  = fin && op_q == OP_MAC32 && sat_q && !clr && !wr_hi;

  // R5: the sticky bit survives a saturating 16x16 accumulate
  a_r5_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mac16_sat_fin && acc_hi[0]) |=> acc_hi[0]);
  a_r5_hi_still: assert property (@(posedge clk) disable iff (!rst_n)
    (mac16_sat_fin && !sat_ovf) |=> $stable(acc_hi));
  // R3: wrapping accumulate leaves a sign-extended 10-bit high word
  a_r3_guard_form: assert property (@(posedge clk) disable iff (!rst_n)
    mac16_wrap_fin |=> ($countones(acc_hi[DW-1:GUARD-1]) == 0 ||
                        $countones(acc_hi[DW-1:GUARD-1]) == DW - GUARD + 1));
  // R7: saturating 32x32 accumulate leaves a 48-bit form
  a_r7_sat48_form: assert property (@(posedge clk) disable iff (!rst_n)
    mac32_sat_fin |=> ($countones(acc_hi[DW-1:KEEP]) == 0 ||
                       $countones(acc_hi[DW-1:KEEP]) == DW - KEEP));
endmodule

// File: tb/tb_mac_unit.sv
`timescale 1ns/1ps
module tb_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [31:0] op_a = '0, op_b = '0, wr_data = '0;
  logic        sat_en = 1'b0, clr = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mac_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .sat_en(sat_en), .clr(clr),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  // reference model state
  logic [31:0] m_hi = '0, m_lo = '0, m_a = '0, m_b = '0;
  logic [1:0]  m_op = '0;
  bit          m_sat = 0, m_busy = 0, m_done = 0;
  string       m_tag = "R12";

  always @(posedge clk) begin : model
    logic [31:0] nh, nl;
    logic [63:0] r;
    longint      p, s, acc;
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_busy = 0; m_done = 0; m_tag = "R12";
    end else begin
      nh = m_hi; nl = m_lo; m_tag = "R10";
      if (m_busy) begin
        case (m_op)
          2'b00: begin
            r = 64'(longint'($signed(m_a)) * longint'($signed(m_b)));
            nh = r[63:32]; nl = r[31:0]; m_tag = "R1";
          end
          2'b01: begin
            r = {32'b0, m_a} * {32'b0, m_b};
            nh = r[63:32]; nl = r[31:0]; m_tag = "R2";
          end
          2'b10: begin
            p = longint'($signed(m_a[15:0])) * longint'($signed(m_b[15:0]));
            if (m_sat) begin
              s = longint'($signed(m_lo)) + p;
              m_tag = "R4 R5";
              if (s > 64'sd2147483647) begin nl = 32'h7FFFFFFF; nh = m_hi | 32'h1; end
              else if (s < -64'sd2147483648) begin nl = 32'h80000000; nh = m_hi | 32'h1; end
              else nl = s[31:0];
            end else begin
              acc = (longint'($signed(m_hi[9:0])) <<< 32) + longint'({32'b0, m_lo}) + p;
              nh = {{22{acc[41]}}, acc[41:32]}; nl = acc[31:0]; m_tag = "R3";
            end
          end
          default: begin
            r = {m_hi, m_lo} + 64'(longint'($signed(m_a)) * longint'($signed(m_b)));
            nh = r[63:32]; nl = r[31:0]; m_tag = "R6";
            if (m_sat) begin
              m_tag = "R7";
              if (nh[31]) nh = nh | 32'hFFFF8000; else nh = nh & 32'h00007FFF;
            end
          end
        endcase
      end
      if (wr_hi) begin nh = wr_data; m_tag = "R9"; end
      if (wr_lo) begin nl = wr_data; m_tag = "R9"; end
      if (clr) begin nh = '0; nl = '0; m_tag = "R8"; end
      if (start && m_busy) m_tag = {m_tag, " R11"};
      m_done = m_busy;
      if (start && !m_busy) begin
        m_op = opcode; m_a = op_a; m_b = op_b; m_sat = sat_en;
      end
      m_busy = start && !m_busy;
      m_hi = nh; m_lo = nl;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (acc_hi !== m_hi || acc_lo !== m_lo) begin
        errors++;
        $display("FAIL %s acc actual %h_%h expected %h_%h at %0t", m_tag,
                 acc_hi, acc_lo, m_hi, m_lo, $time);
      end
      if (done !== m_done) begin
        errors++;
        $display("FAIL R10 %s done actual %b expected %b at %0t", m_tag, done, m_done, $time);
      end
    end
  end

  task automatic idle();
    start = 0; clr = 0; wr_hi = 0; wr_lo = 0;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input bit sat);
    opcode = op; op_a = a; op_b = b; sat_en = sat; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
  endtask

  task automatic load(input bit hi_sel, input logic [31:0] d);
    wr_data = d; wr_hi = hi_sel; wr_lo = !hi_sel;
    @(negedge clk);
    wr_hi = 0; wr_lo = 0;
  endtask

  function automatic logic [31:0] pick(input int k);
    case (k % 8)
      0: return 32'h00007FFF;
      1: return 32'h00008000;
      2: return 32'hFFFFFFFF;
      3: return 32'h80000000;
      4: return 32'h7FFFFFFF;
      5: return 32'h0000FFFF;
      6: return 32'h00000001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);          // R12 reset state compared each cycle
    rst_n = 1;
    @(negedge clk);
    run_op(2'b00, 32'hFFFFFFFE, 32'd3, 0);            // R1
    run_op(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);     // R2
    load(0, 32'h7FFFFF00); load(1, 32'h0);             // R9
    run_op(2'b10, 32'h7FFF, 32'h7FFF, 1);             // R4 positive clamp
    run_op(2'b10, 32'h1, 32'h1, 1);                   // R5 sticky kept
    load(0, 32'h80000010);
    run_op(2'b10, 32'h8000, 32'h7FFF, 1);             // R4 negative clamp
    clr = 1; idle();                                  // R8
    load(1, 32'h000001FF); load(0, 32'hFFFFFFFF);
    run_op(2'b10, 32'h1, 32'h1, 0);                   // R3 carry across bit 9
    run_op(2'b10, 32'hFFFF, 32'h1, 0);                // R3 negative product
    run_op(2'b11, 32'h12345678, 32'h9ABCDEF0, 0);     // R6
    load(1, 32'h00007FFF); load(0, 32'hFFFFFFFF);
    run_op(2'b11, 32'h1, 32'h1, 1);                   // R7 positive
    clr = 1; idle();
    run_op(2'b11, 32'hFFFFFFFF, 32'h1, 1);            // R7 negative
    // R11: start held two cycles
    opcode = 2'b00; op_a = 32'd7; op_b = 32'd9; start = 1;
    @(negedge clk); op_a = 32'd100; @(negedge clk); start = 0;
    idle();
    // R9: write lands in the completion cycle
    run_op(2'b01, 32'd5, 32'd6, 0);
    opcode = 2'b00; op_a = 32'd3; op_b = 32'd4; start = 1;
    @(negedge clk); start = 0; wr_hi = 1; wr_data = 32'hCAFE0000;
    @(negedge clk); wr_hi = 0;
    idle();
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 99);
      opcode = 2'($urandom); sat_en = $urandom_range(0, 1);
      op_a = pick($urandom); op_b = pick($urandom);
      start = k < 55;
      clr = k == 99;
      wr_hi = k >= 90 && k < 94;
      wr_lo = k >= 94 && k < 98;
      wr_data = pick($urandom);
      @(negedge clk);
    end
    idle(); idle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule